// File: doc/BRIEF.md
# Word-Length Configurable Arithmetic Slice Array

The block holds eight 4-bit arithmetic slices that a two-bit mode input fuses into lanes of 4, 8, 16 or 32 bits. Every operation carries its own mode, so the lane width can change from one operation to the next without a reconfiguration phase. Inside a lane the carry runs from each slice into the next higher one. At a lane boundary the carry is cut, and the carry-in is seeded for the operation in progress.

Each lane can add, subtract or compare. The two 32-bit operands are packed, with lane g in bits g*w to g*w+w-1 for lane width w. The result is packed the same way. Each lane also returns a carry flag, a signed less-than flag and an equal flag. All outputs are registered, so they change at the clock edge that samples the valid strobe.

Top module: `wlc_slice_array`

## Requirements
- R1: While reset is asserted, result_o, carry_o, lt_o and eq_o are all zero.
- R2: The mode encoding gives the lane width w: 2'b00 gives eight 4-bit lanes, 2'b01 gives four 8-bit lanes, 2'b10 gives two 16-bit lanes and 2'b11 gives one 32-bit lane. For opcode 2'b00 (add), each lane of result_o is (A_lane + B_lane) mod 2^w. No carry crosses into another lane.
- R3: For add, carry_o bit g is the carry out of the most significant bit of lane g.
- R4: For opcode 2'b01 (subtract), each lane of result_o is (A_lane - B_lane) mod 2^w. carry_o bit g is 1 exactly when A_lane >= B_lane as unsigned values, meaning no borrow.
- R5: For opcode 2'b10 (compare), result_o holds the lane differences and carry_o is set as for subtract. lt_o bit g is 1 when A_lane < B_lane as signed two's-complement values. eq_o bit g is 1 when A_lane == B_lane. lt_o and eq_o are never both set for the same lane.
- R6: For add, subtract and opcode 2'b11, lt_o and eq_o are zero. Opcode 2'b11 produces the same result and carry as add.
- R7: Flag bit g belongs to lane g. Flag bits whose index is at or above the number of lanes in the current mode are zero.
- R8: The outputs take the new values at the rising clock edge where in_valid is high. While in_valid is low they hold their values, whatever the other inputs do.
- R9: The mode is sampled together with each operation. On back-to-back valid cycles with different modes, each result follows its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| mode_i | input | 2 | Lane-width selector |
| op_i | input | 2 | Opcode: add, subtract, compare, add |
| a_i | input | 32 | Packed operand A |
| b_i | input | 32 | Packed operand B |
| result_o | output | 32 | Packed registered result |
| carry_o | output | 8 | Per-lane carry / no-borrow flag |
| lt_o | output | 8 | Per-lane signed less-than flag |
| eq_o | output | 8 | Per-lane equal flag |

## Verification
Two things share a cycle in this block: a carry that would cross a slice boundary, and the mode that decides whether that boundary is a lane edge. The operands are built so that every nibble position generates or propagates a carry, for example with replicated nibbles, all-ones values and sign-boundary values. These operands are swept through every mode and opcode. Separately, the mode is switched on consecutive valid cycles. Each registered result and flag is compared against lane values that the bench extracts and evaluates with ordinary integer arithmetic.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_ADDX = 2'b11
  } wlc_op_e;

  // Signed less-than of a lane from the sign bits of A and B and the sign bit of A-B.
  // When the signs agree the difference cannot overflow, so its sign decides.
  function automatic logic lane_signed_lt(input logic a_sign, input logic b_sign,
                                          input logic diff_sign);
    return (a_sign != b_sign) ? a_sign : diff_sign;
  endfunction

  function automatic logic op_subtracts(input wlc_op_e op);
    return (op == OP_SUB) || (op == OP_CMP);
  endfunction

endpackage

// File: rtl/wlc_slice.sv
module wlc_slice #(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  input  logic               inv_b,
  output logic [SLICE_W-1:0] sum,
  output logic               cout,
  output logic               eq,
  output logic               a_sign,
  output logic               b_sign
);
  logic [SLICE_W-1:0] b_eff;
  logic [SLICE_W:0]   total;

  assign b_eff  = inv_b ? ~b : b;
  assign total  = {1'b0, a} + {1'b0, b_eff} + {{SLICE_W{1'b0}}, cin};
  assign sum    = total[SLICE_W-1:0];
  assign cout   = total[SLICE_W];
  assign eq     = (a == b);
  assign a_sign = a[SLICE_W-1];
  assign b_sign = b[SLICE_W-1];
endmodule

// File: rtl/wlc_chain_ctrl.sv
module wlc_chain_ctrl #(
  parameter int NUM_SLICES = 8,
  parameter int MODE_W     = 2
) (
  input  logic [MODE_W-1:0]     mode,
  output logic [NUM_SLICES-1:0] grp_start,
  output logic [NUM_SLICES-1:0] grp_top
);
  always_comb begin
    int unsigned span;
    span = 32'd1 << mode;
    for (int i = 0; i < NUM_SLICES; i++) begin
      grp_start[i] = ((i % span) == 0);
      grp_top[i]   = (((i + 1) % span) == 0);
    end
  end
endmodule

// File: rtl/wlc_flag_gather.sv
module wlc_flag_gather #(
  parameter int NUM_SLICES = 8,
  parameter int MODE_W     = 2
) (
  input  logic [MODE_W-1:0]     mode,
  input  logic [NUM_SLICES-1:0] slice_cout,
  input  logic [NUM_SLICES-1:0] slice_lt,
  input  logic [NUM_SLICES-1:0] eq_run,
  output logic [NUM_SLICES-1:0] grp_carry,
  output logic [NUM_SLICES-1:0] grp_lt,
  output logic [NUM_SLICES-1:0] grp_eq
);
  // Lane g reports from its top slice. Lanes that do not exist report zero.
  always_comb begin
    int unsigned span;
    int unsigned top;
    span      = 32'd1 << mode;
    grp_carry = '0;
    grp_lt    = '0;
    grp_eq    = '0;
    for (int g = 0; g < NUM_SLICES; g++) begin
      top = g * span + span - 1;
      if (top < NUM_SLICES) begin
        grp_carry[g] = slice_cout[top];
        grp_lt[g]    = slice_lt[top];
        grp_eq[g]    = eq_run[top];
      end
    end
  end
endmodule

// File: rtl/wlc_slice_array.sv
module wlc_slice_array
  import wlc_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 8,
  parameter int MODE_W     = 2,
  localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [MODE_W-1:0]     mode_i,
  input  logic [1:0]            op_i,
  input  logic [DATA_W-1:0]     a_i,
  input  logic [DATA_W-1:0]     b_i,
  output logic [DATA_W-1:0]     result_o,
  output logic [NUM_SLICES-1:0] carry_o,
  output logic [NUM_SLICES-1:0] lt_o,
  output logic [NUM_SLICES-1:0] eq_o
);
  wlc_op_e op;
  logic    do_sub;
  logic    do_cmp;

  assign op     = wlc_op_e'(op_i);
  assign do_sub = op_subtracts(op);
  assign do_cmp = (op == OP_CMP);

  // Named internal events
  logic [NUM_SLICES-1:0] grp_start;
  logic [NUM_SLICES-1:0] grp_top;
  logic [NUM_SLICES-1:0] slice_cin;
  logic [NUM_SLICES-1:0] slice_cout;
  logic [NUM_SLICES-1:0] slice_eq;
  logic [NUM_SLICES-1:0] slice_lt;
  logic [NUM_SLICES-1:0] eq_run;
  logic [DATA_W-1:0]     sum_all;
  logic [NUM_SLICES-1:0] grp_carry;
  logic [NUM_SLICES-1:0] grp_lt;
  logic [NUM_SLICES-1:0] grp_eq;

  wlc_chain_ctrl #(.NUM_SLICES(NUM_SLICES), .MODE_W(MODE_W)) u_ctrl (
    .mode      (mode_i),
    .grp_start (grp_start),
    .grp_top   (grp_top)
  );

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    logic a_sign;
    logic b_sign;

    if (i == 0) begin : g_first
      assign slice_cin[i] = do_sub;
      assign eq_run[i]    = slice_eq[i];
    end else begin : g_rest
      // A lane edge cuts the chain and seeds the carry-in; inside a lane the carry ripples upward.
      assign slice_cin[i] = grp_start[i] ? do_sub : slice_cout[i-1];
      assign eq_run[i]    = slice_eq[i] & (grp_start[i] | eq_run[i-1]);
    end

    wlc_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a      (a_i[i*SLICE_W +: SLICE_W]),
      .b      (b_i[i*SLICE_W +: SLICE_W]),
      .cin    (slice_cin[i]),
      .inv_b  (do_sub),
      .sum    (sum_all[i*SLICE_W +: SLICE_W]),
      .cout   (slice_cout[i]),
      .eq     (slice_eq[i]),
      .a_sign (a_sign),
      .b_sign (b_sign)
    );

    assign slice_lt[i] = lane_signed_lt(a_sign, b_sign, sum_all[i*SLICE_W + SLICE_W - 1]);
  end

  wlc_flag_gather #(.NUM_SLICES(NUM_SLICES), .MODE_W(MODE_W)) u_gather (
    .mode       (mode_i),
    .slice_cout (slice_cout),
    .slice_lt   (slice_lt),
    .eq_run     (eq_run),
    .grp_carry  (grp_carry),
    .grp_lt     (grp_lt),
    .grp_eq     (grp_eq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      carry_o  <= '0;
      lt_o     <= '0;
      eq_o     <= '0;
    end else if (in_valid) begin
      result_o <= sum_all;
      carry_o  <= grp_carry;
      lt_o     <= do_cmp ? grp_lt : '0;
      eq_o     <= do_cmp ? grp_eq : '0;
    end
  end

  // R8: outputs hold while no operation is offered
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result_o) && $stable(carry_o) && $stable(lt_o) && $stable(eq_o)));

  // R5: a lane is never both less and equal
  assert_lt_eq_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_o & eq_o) == '0);

  // R5: full-width compare of equal operands reports equal
  assert_cmp_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == 2'b10 && mode_i == MODE_W'(3) && a_i == b_i) |=> eq_o[0]);

  // R4: subtracting equal values never borrows
  assert_sub_noborrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == 2'b01 && a_i == b_i) |=> carry_o[0]);

  // R6: compare flags stay clear for non-compare opcodes
  assert_noncmp_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i != 2'b10) |=> (lt_o == '0 && eq_o == '0));

  // R7: one-lane mode leaves the upper flag bits clear
  assert_unused_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_i == MODE_W'(3)) |=>
      (carry_o[NUM_SLICES-1:1] == '0 && lt_o[NUM_SLICES-1:1] == '0 && eq_o[NUM_SLICES-1:1] == '0));
endmodule

// File: tb/wlc_slice_array_bench.sv
module wlc_slice_array_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o;
  logic [7:0]  carry_o, lt_o, eq_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_r;
  logic [7:0]  exp_c, exp_l, exp_e;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  wlc_slice_array u_wlc_slice_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_i(mode_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .carry_o(carry_o), .lt_o(lt_o), .eq_o(eq_o)
  );

  // Reference: per-lane integer arithmetic on extracted fields
  task automatic model(input logic [1:0] m, input logic [1:0] op,
                       input logic [31:0] a, input logic [31:0] b);
    int w;
    int n;
    longint unsigned msk, al, bl, v;
    longint sa, sb;
    w = 4 << m;
    n = 8 >> m;
    msk = (64'd1 << w) - 1;
    exp_r = '0; exp_c = '0; exp_l = '0; exp_e = '0;
    for (int g = 0; g < n; g++) begin
      al = (64'(a) >> (g * w)) & msk;
      bl = (64'(b) >> (g * w)) & msk;
      if (op == 2'b01 || op == 2'b10) begin
        v = (al - bl) & msk;
        exp_c[g] = (al >= bl);
      end else begin
        v = al + bl;
        exp_c[g] = v[w];
        v = v & msk;
      end
      exp_r = exp_r | 32'(v << (g * w));
      if (op == 2'b10) begin
        sa = longint'(al) - (((al >> (w - 1)) & 1) != 0 ? longint'(64'd1 << w) : 0);
        sb = longint'(bl) - (((bl >> (w - 1)) & 1) != 0 ? longint'(64'd1 << w) : 0);
        exp_l[g] = (sa < sb);
        exp_e[g] = (al == bl);
      end
    end
  endtask

  task automatic check(input string tag);
    total++;
    if (result_o !== exp_r || carry_o !== exp_c || lt_o !== exp_l || eq_o !== exp_e) begin
      bad++;
      $display("FAIL %s mode=%0d op=%0d a=%h b=%h got r=%h c=%h l=%h e=%h exp r=%h c=%h l=%h e=%h",
               tag, mode_i, op_i, a_i, b_i, result_o, carry_o, lt_o, eq_o,
               exp_r, exp_c, exp_l, exp_e);
    end
  endtask

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'b00:   return "R2/R3/R7";
      2'b01:   return "R4/R7";
      2'b10:   return "R5/R7";
      default: return "R6";
    endcase
  endfunction

  // Drive on the falling edge, capture at the next rising edge, check on the falling edge after it
  task automatic run_op(input logic [1:0] m, input logic [1:0] op,
                        input logic [31:0] a, input logic [31:0] b, input string tag);
    mode_i = m; op_i = op; a_i = a; b_i = b; in_valid = 1'b1;
    model(m, op, a, b);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    logic [31:0] corners [6];
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF; corners[2] = 32'h7FFF_FFFF;
    corners[3] = 32'h8000_0000; corners[4] = 32'h8888_8888; corners[5] = 32'h7777_7777;

    @(negedge clk);
    // R1: reset state
    total++;
    if (result_o !== '0 || carry_o !== '0 || lt_o !== '0 || eq_o !== '0) begin
      bad++;
      $display("FAIL R1 got r=%h c=%h l=%h e=%h exp all zero", result_o, carry_o, lt_o, eq_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every mode and opcode with carries and borrows at every slice edge (R2 R3 R4 R5 R6 R7)
    for (int m = 0; m < 4; m++) begin
      for (int op = 0; op < 4; op++) begin
        for (int x = 0; x < 16; x++) begin
          for (int y = 0; y < 16; y++) begin
            run_op(2'(m), 2'(op), {8{4'(x)}}, {8{4'(y)}}, tag_of(2'(op)));
          end
        end
        for (int i = 0; i < 6; i++) begin
          for (int j = 0; j < 6; j++) begin
            run_op(2'(m), 2'(op), corners[i], corners[j], tag_of(2'(op)));
          end
        end
        for (int k = 0; k < 40; k++) begin
          logic [31:0] ra;
          rng = next_rand(rng); ra = rng;
          rng = next_rand(rng);
          run_op(2'(m), 2'(op), ra, (k % 5 == 0) ? ra : rng, tag_of(2'(op)));
        end
      end
    end

    // R9: mode switches on consecutive valid cycles
    for (int k = 0; k < 64; k++) begin
      logic [31:0] ra;
      rng = next_rand(rng); ra = rng;
      rng = next_rand(rng);
      run_op(2'(k % 4), 2'((k / 4) % 4), ra, rng, "R9");
      run_op(2'((k + 3) % 4), 2'((k / 4) % 4), 32'hFFFF_FFFF, 32'h0000_0001, "R9");
    end

    // R8: with the strobe low, changed inputs must not reach the outputs
    run_op(2'b01, 2'b10, 32'h1234_5678, 32'h1234_0000, "R8");
    in_valid = 1'b0;
    mode_i = 2'b11; op_i = 2'b00; a_i = 32'hFFFF_FFFF; b_i = 32'h0000_0001;
    repeat (3) @(negedge clk);
    check("R8");
    op_i = 2'b10; a_i = 32'h0; b_i = 32'h0;
    @(negedge clk);
    check("R8");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule